// File: doc/BRIEF.md
# Event Counter Bank for Performance Monitoring

The block holds a bank of general-purpose event counters. A wide bus of single-bit event lines comes in from decode logic elsewhere in the chip. Each counter picks one line from that bus through its own select field. Per counter, software chooses between two ways of counting: once for every low-to-high transition of the line, or once for every clock cycle the line is high. A small word-addressed register port configures the bank and reads back every counter at any time.

A monitoring-mode register either runs the bank in one of three active modes or holds it in halt. In halt every counter freezes on the same edge, so a read sweep returns one coherent snapshot. Changing to a different active mode, or rewriting a select word while active, zeroes all counters at once and restarts counting. A counter that passes its top value wraps to zero, keeps counting and raises its own sticky overflow flag. The OR of all flags drives a single interrupt line, and flags are cleared by writing ones to the status word.

Top module: `evctr_bank`

## Requirements
- R1: After reset the mode is halt (0), all edge bits, select fields, overflow flags and counters read 0, and irq is low.
- R2: A counter whose edge bit is 0 gains exactly one for every clock cycle its selected event is high while the mode is active (1 north, 2 south, 3 memory).
- R3: A counter whose edge bit is 1 gains one only in a cycle where its selected event is high and was low in the previous cycle. The edge control word is at address 1, with bit i for counter i.
- R4: Counter i counts event line `events[s]`, where s is its 8-bit select field. Select word 4 holds counters 0..3 and word 5 holds counters 4..7, with counter i at bits 8*(i mod 4) upward.
- R5: A write to either select word while the mode is active sets every counter to 0 on that edge. Counting resumes from the next cycle.
- R6: A write to the mode word (address 0, bits 1:0) with an active value different from the current mode zeroes every counter. Writing the current mode again leaves the counters running.
- R7: While the mode is halt, no counter changes, including on a select word write.
- R8: A counter at its all-ones value that receives one more count becomes 0 and sets its overflow flag, status bit i at address 2.
- R9: irq is high exactly while at least one overflow flag is set.
- R10: A write to the status word clears the flags whose written bits are 1 and keeps the others. A wrap in the same cycle leaves its flag set.
- R11: Address 16+i reads counter i, zero-extended. Addresses 0, 1, 2, 4 and 5 read back the mode, edge, status and select words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Word address for write and read |
| wdata | input | DATA_W | Write data |
| events | input | 2**SEL_W | Event lines |
| rdata | output | DATA_W | Read data for addr, combinational |
| irq | output | 1 | Any-overflow interrupt |

## Verification
The bench drives four event patterns, each under mixed edge and level counters, with several counters sharing a line. A long all-high run separates edge counting (one count) from level counting (every cycle). A one-cycle toggle makes both kinds of counter agree, which exposes an off-by-one in the previous-value register. Pseudo-random traffic covers irregular gaps, and a held-high line drives small bench-sized counters through wrap-around and the flags. Halt stretches with live traffic, select rewrites and mode changes to the same mode and to a new one separate freezing from clearing.

// File: rtl/evctr_pkg.sv
package evctr_pkg;
  typedef enum logic [1:0] {
    MODE_HALT  = 2'd0,
    MODE_NORTH = 2'd1,
    MODE_SOUTH = 2'd2,
    MODE_MEM   = 2'd3
  } mon_mode_e;

  localparam int ADDR_W = 5;
  localparam int A_MODE = 0;
  localparam int A_EDGE = 1;
  localparam int A_STAT = 2;
  localparam int A_SEL0 = 4;
  localparam int A_CTR0 = 16;
endpackage

// File: rtl/evctr_rst_sync.sv
module evctr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sync_n = s2_q;
endmodule

// File: rtl/evctr_regs.sv
module evctr_regs
  import evctr_pkg::*;
#(
  parameter int NUM_CTR = 8,
  parameter int SEL_W   = 8,
  parameter int DATA_W  = 32,
  localparam int SEL_PER_WORD = DATA_W / SEL_W,
  localparam int SEL_WORDS    = (NUM_CTR + SEL_PER_WORD - 1) / SEL_PER_WORD
) (
  input  logic                     clk,
  input  logic                     rst_ni,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [NUM_CTR-1:0]       ovf,
  output mon_mode_e                mode_q,
  output logic [NUM_CTR-1:0]       edge_q,
  output logic [NUM_CTR*SEL_W-1:0] sel_q,
  output logic [NUM_CTR-1:0]       flag_q,
  output logic                     ctr_clr,
  output logic                     count_en
);
  mon_mode_e                mode_d;
  logic [NUM_CTR-1:0]       edge_d, flag_d;
  logic [NUM_CTR*SEL_W-1:0] sel_d;
  logic                     cfg_we;
  int                       ai;

  assign ai = int'(addr);

  always_comb begin
    mode_d  = mode_q;
    edge_d  = edge_q;
    sel_d   = sel_q;
    flag_d  = flag_q;
    ctr_clr = 1'b0;
    cfg_we  = 1'b0;
    if (wr_en) begin
      if (ai == A_MODE) begin
        mode_d = mon_mode_e'(wdata[1:0]);
        cfg_we = 1'b1;
        if (wdata[1:0] != mode_q && wdata[1:0] != MODE_HALT) ctr_clr = 1'b1;
      end else if (ai == A_EDGE) begin
        edge_d = wdata[NUM_CTR-1:0];
        cfg_we = 1'b1;
      end else if (ai == A_STAT) begin
        flag_d = flag_q & ~wdata[NUM_CTR-1:0];
      end else if (ai >= A_SEL0 && ai < A_SEL0 + SEL_WORDS) begin
        cfg_we  = 1'b1;
        ctr_clr = (mode_q != MODE_HALT);
        for (int k = 0; k < SEL_PER_WORD; k++) begin
          if ((ai - A_SEL0) * SEL_PER_WORD + k < NUM_CTR)
            sel_d[((ai - A_SEL0) * SEL_PER_WORD + k) * SEL_W +: SEL_W] = wdata[k*SEL_W +: SEL_W];
        end
      end
    end
    flag_d = flag_d | ovf;
  end

  assign count_en = (mode_q != MODE_HALT);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_HALT;
      edge_q <= '0;
      sel_q  <= '0;
    end else if (cfg_we) begin
      mode_q <= mode_d;
      edge_q <= edge_d;
      sel_q  <= sel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= flag_d;
  end
endmodule

// File: rtl/evctr_cell.sv
module evctr_cell #(
  parameter int CTR_W = 27,
  parameter int SEL_W = 8,
  localparam int NUM_EV = 1 << SEL_W
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic [NUM_EV-1:0] ev_now,
  input  logic [NUM_EV-1:0] ev_prev,
  input  logic [SEL_W-1:0]  sel,
  input  logic              edge_mode,
  input  logic              en,
  input  logic              clr,
  output logic [CTR_W-1:0]  count_q,
  output logic              ovf
);
  logic             hit, inc, at_max, cnt_we;
  logic [CTR_W-1:0] count_d;

  always_comb begin
    hit     = edge_mode ? (ev_now[sel] & ~ev_prev[sel]) : ev_now[sel];
    inc     = en & hit & ~clr;
    at_max  = &count_q;
    ovf     = inc & at_max;
    cnt_we  = clr | inc;
    count_d = clr ? '0 : count_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     count_q <= '0;
    else if (cnt_we) count_q <= count_d;
  end
endmodule

// File: rtl/evctr_bank.sv
module evctr_bank
  import evctr_pkg::*;
#(
  parameter int NUM_CTR = 8,
  parameter int CTR_W   = 27,
  parameter int SEL_W   = 8,
  parameter int DATA_W  = 32,
  localparam int NUM_EV = 1 << SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [4:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NUM_EV-1:0] events,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int SEL_PER_WORD = DATA_W / SEL_W;
  localparam int SEL_WORDS    = (NUM_CTR + SEL_PER_WORD - 1) / SEL_PER_WORD;

  logic                     rst_sync_n;
  mon_mode_e                mode_q;
  logic [NUM_CTR-1:0]       edge_q, flag_q, ovf;
  logic [NUM_CTR*SEL_W-1:0] sel_q;
  logic                     ctr_clr, count_en;
  logic [NUM_EV-1:0]        events_q;
  logic [NUM_CTR*CTR_W-1:0] ctr_flat;
  int                       ai;

  evctr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  evctr_regs #(
    .NUM_CTR (NUM_CTR),
    .SEL_W   (SEL_W),
    .DATA_W  (DATA_W)
  ) u_regs (
    .clk      (clk),
    .rst_ni   (rst_sync_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .ovf      (ovf),
    .mode_q   (mode_q),
    .edge_q   (edge_q),
    .sel_q    (sel_q),
    .flag_q   (flag_q),
    .ctr_clr  (ctr_clr),
    .count_en (count_en)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) events_q <= '0;
    else             events_q <= events;
  end

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    evctr_cell #(
      .CTR_W (CTR_W),
      .SEL_W (SEL_W)
    ) u_cell (
      .clk       (clk),
      .rst_ni    (rst_sync_n),
      .ev_now    (events),
      .ev_prev   (events_q),
      .sel       (sel_q[i*SEL_W +: SEL_W]),
      .edge_mode (edge_q[i]),
      .en        (count_en),
      .clr       (ctr_clr),
      .count_q   (ctr_flat[i*CTR_W +: CTR_W]),
      .ovf       (ovf[i])
    );
  end

  assign ai  = int'(addr);
  assign irq = |flag_q;

  always_comb begin
    rdata = '0;
    if (ai == A_MODE)      rdata[1:0] = mode_q;
    else if (ai == A_EDGE) rdata[NUM_CTR-1:0] = edge_q;
    else if (ai == A_STAT) rdata[NUM_CTR-1:0] = flag_q;
    else if (ai >= A_SEL0 && ai < A_SEL0 + SEL_WORDS) begin
      for (int k = 0; k < SEL_PER_WORD; k++) begin
        if ((ai - A_SEL0) * SEL_PER_WORD + k < NUM_CTR)
          rdata[k*SEL_W +: SEL_W] = sel_q[((ai - A_SEL0) * SEL_PER_WORD + k) * SEL_W +: SEL_W];
      end
    end else if (ai >= A_CTR0 && ai < A_CTR0 + NUM_CTR)
      rdata[CTR_W-1:0] = ctr_flat[(ai - A_CTR0) * CTR_W +: CTR_W];
  end
endmodule

// File: rtl/evctr_bank_sva.sv
module evctr_bank_sva
  import evctr_pkg::*;
#(
  parameter int NUM_CTR   = 8,
  parameter int CTR_W     = 27,
  parameter int DATA_W    = 32,
  parameter int SEL_WORDS = 2
) (
  input logic                     clk,
  input logic                     rst_ni,
  input logic                     wr_en,
  input logic [4:0]               addr,
  input logic [DATA_W-1:0]        wdata,
  input logic [1:0]               mode_q,
  input logic [NUM_CTR-1:0]       flag_q,
  input logic [NUM_CTR*CTR_W-1:0] ctr_flat,
  input logic                     irq
);
  logic sel_wr, mode_wr, stat_wr;
  assign sel_wr  = wr_en && int'(addr) >= A_SEL0 && int'(addr) < A_SEL0 + SEL_WORDS;
  assign mode_wr = wr_en && int'(addr) == A_MODE;
  assign stat_wr = wr_en && int'(addr) == A_STAT;

  p_sel_clear_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (sel_wr && mode_q != 2'd0) |=> (ctr_flat == '0));

  p_halt_freeze_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode_q == 2'd0 && !mode_wr) |=> $stable(ctr_flat));

  p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (irq && !stat_wr) |=> irq);

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_chk
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_ni)
      (ctr_flat[i*CTR_W +: CTR_W] != $past(ctr_flat[i*CTR_W +: CTR_W])) |->
      (ctr_flat[i*CTR_W +: CTR_W] == $past(ctr_flat[i*CTR_W +: CTR_W]) + 1'b1 ||
       ctr_flat[i*CTR_W +: CTR_W] == '0));

    p_wrap_flag_r8: assert property (@(posedge clk) disable iff (!rst_ni)
      $rose(flag_q[i]) |-> (ctr_flat[i*CTR_W +: CTR_W] == '0 &&
                            $past(ctr_flat[i*CTR_W +: CTR_W]) == {CTR_W{1'b1}}));

    p_flag_clear_r10: assert property (@(posedge clk) disable iff (!rst_ni)
      $fell(flag_q[i]) |-> $past(stat_wr && wdata[i]));
  end
endmodule

bind evctr_bank evctr_bank_sva #(
  .NUM_CTR   (NUM_CTR),
  .CTR_W     (CTR_W),
  .DATA_W    (DATA_W),
  .SEL_WORDS (SEL_WORDS)
) u_sva (
  .clk      (clk),
  .rst_ni   (rst_sync_n),
  .wr_en    (wr_en),
  .addr     (addr),
  .wdata    (wdata),
  .mode_q   (mode_q),
  .flag_q   (flag_q),
  .ctr_flat (ctr_flat),
  .irq      (irq)
);

// File: tb/evctr_bank_tb.sv
`timescale 1ns/10ps
module evctr_bank_tb_top;
  localparam int NC    = 8;
  localparam int CW    = 10;
  localparam int MAXV  = (1 << CW) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [255:0] events = '0;
  logic [31:0] rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference model state
  int        m_ctr [NC];
  bit        m_flag [NC];
  bit        m_edge [NC];
  int        m_sel [NC];
  int        m_mode = 0;
  bit [255:0] m_prev = '0;

  always #5 clk = ~clk;

  evctr_bank #(.CTR_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .events(events), .rdata(rdata), .irq(irq)
  );

  initial begin
    for (int i = 0; i < NC; i++) begin
      m_ctr[i] = 0; m_flag[i] = 0; m_edge[i] = 0; m_sel[i] = 0;
    end
  end

  always @(posedge clk) begin
    bit clr;
    bit inc [NC];
    int nmode;
    int ai;
    clr = 0;
    nmode = m_mode;
    ai = int'(addr);
    for (int i = 0; i < NC; i++) begin
      bit ev;
      ev = events[m_sel[i]];
      inc[i] = (m_mode != 0) && (m_edge[i] ? (ev && !m_prev[m_sel[i]]) : ev);
    end
    if (wr_en) begin
      if (ai == 0) begin
        if (int'(wdata[1:0]) != m_mode && wdata[1:0] != 2'd0) clr = 1;
        nmode = int'(wdata[1:0]);
      end else if (ai == 1) begin
        for (int i = 0; i < NC; i++) m_edge[i] = wdata[i];
      end else if (ai == 2) begin
        for (int i = 0; i < NC; i++) if (wdata[i]) m_flag[i] = 0;
      end else if (ai == 4 || ai == 5) begin
        for (int k = 0; k < 4; k++) m_sel[(ai-4)*4+k] = int'(wdata[k*8 +: 8]);
        if (m_mode != 0) clr = 1;
      end
    end
    for (int i = 0; i < NC; i++) begin
      if (clr) m_ctr[i] = 0;
      else if (inc[i]) begin
        if (m_ctr[i] == MAXV) begin m_ctr[i] = 0; m_flag[i] = 1; end
        else m_ctr[i] = m_ctr[i] + 1;
      end
    end
    m_mode = nmode;
    m_prev = events;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare all outputs against the model, then drive the next cycle
  task automatic cyc(input bit w, input int a, input logic [31:0] d);
    logic [31:0] fl;
    @(negedge clk);
    #1;
    fl = '0;
    for (int i = 0; i < NC; i++) fl[i] = m_flag[i];
    chk((cur_req == "R1") ? "R1" : "R9", "irq", {31'b0, irq}, {31'b0, (fl != 0)});
    addr = 5'd2; #0.3;
    chk((cur_req == "R1") ? "R1" : "R10", "status", rdata, fl);
    addr = 5'd0; #0.3;
    chk("R11", "mode", rdata, m_mode);
    for (int i = 0; i < NC; i++) begin
      addr = 5'(16 + i); #0.3;
      chk(cur_req, $sformatf("ctr%0d", i), rdata, m_ctr[i]);
    end
    wr_en = w;
    addr  = 5'(a);
    wdata = d;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(0, 0, 0);
  endtask

  task automatic rand_ev(input int n);
    for (int k = 0; k < n; k++) begin
      for (int j = 0; j < 8; j++) events[j*32 +: 32] = $urandom();
      cyc(0, 0, 0);
    end
  endtask

  initial begin
    fork
      begin
        #(200000 * 10);
        if (!done) begin
          total++; bad++;
          $display("FAIL watchdog expired");
          $display("test done: total=%0d bad=%0d", total, bad);
          $finish;
        end
      end
    join_none

    // R1: reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(5);

    // R4/R11: configure select words and edge bits while halted
    cur_req = "R4";
    cyc(1, 4, {8'd0, 8'd200, 8'd5, 8'd5});
    cyc(1, 5, {8'd64, 8'd17, 8'd17, 8'd255});
    cyc(1, 1, 32'h0000_0042);
    cyc(0, 0, 0);
    addr = 5'd4; #0.3; chk("R11", "sel word0", rdata, {8'd0, 8'd200, 8'd5, 8'd5});
    addr = 5'd5; #0.3; chk("R11", "sel word1", rdata, {8'd64, 8'd17, 8'd17, 8'd255});
    addr = 5'd1; #0.3; chk("R11", "edge word", rdata, 32'h42);
    addr = 5'd0;

    // R6: start north mode (clears)
    cur_req = "R6";
    cyc(1, 0, 1);
    // R2/R3: held-high run separates edge and level
    cur_req = "R2";
    events = '1;
    idle(20);
    // R3: single-cycle toggle
    cur_req = "R3";
    for (int k = 0; k < 40; k++) begin
      events = (k % 2) ? '0 : '1;
      cyc(0, 0, 0);
    end
    cur_req = "R4";
    rand_ev(200);

    // R6: same mode write does not clear
    cur_req = "R6";
    cyc(1, 0, 1);
    rand_ev(10);

    // R7: halt freezes, select write during halt leaves counters
    cur_req = "R7";
    cyc(1, 0, 0);
    rand_ev(20);
    cyc(1, 4, {8'd5, 8'd200, 8'd9, 8'd5});
    rand_ev(20);

    // R6: new active mode clears
    cur_req = "R6";
    cyc(1, 0, 2);
    rand_ev(30);

    // R5: select write while active clears
    cur_req = "R5";
    cyc(1, 5, {8'd64, 8'd17, 8'd17, 8'd255});
    rand_ev(30);

    // R8: hold all high to wrap level counters
    cur_req = "R8";
    events = '1;
    idle(MAXV + 20);
    events = '0;
    idle(3);

    // R10: partial clear keeps other flags
    cur_req = "R10";
    cyc(1, 2, 32'h10);
    idle(3);
    cyc(1, 2, 32'hff);
    idle(3);

    // R8/R9: wrap again with mode 3 and later clear
    cur_req = "R8";
    cyc(1, 0, 3);
    events = '1;
    idle(MAXV + 5);
    cur_req = "R10";
    cyc(1, 2, 32'hff);
    events = '0;
    idle(5);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule